// File: doc/BRIEF.md
# Frame-Triggered Indexed DMA Channel

This block is one memory-to-memory DMA channel for 16-bit elements. A transfer is organised as frames. Each frame holds a programmable number of elements, and the whole transfer holds a programmable number of frames. One pulse on the hardware trigger moves exactly one frame. The channel then goes idle and waits for the next pulse. A software start pulse does the same job, for example to prefill a peripheral buffer before the peripheral begins to consume it.

Source and destination each have their own element step and frame step. Inside a frame, each pointer advances by its element step after every element. At a frame boundary, each pointer restarts at that frame's start address plus its frame step. With a zero destination frame step and a non-zero source frame step, the channel gathers interleaved chunks of a large array into the same small window of a buffer RAM, one chunk per trigger.

Each element is moved as one read followed by one write on a simple request/acknowledge memory port. The next read is issued only after the previous write has been accepted.

Top module: `dma_frame_chan`

## Requirements
- R1: After reset, rd_req, wr_req, busy and done are 0, and the channel ignores hw_trig and sw_start until it has been armed with cfg_arm.
- R2: A cfg_arm pulse captures all cfg_* inputs, clears done and any pending trigger, aborts any frame in progress, and sets both pointers to their base addresses.
- R3: Each accepted trigger moves exactly cfg_elem_cnt elements (a count of at least 1). The channel then returns to idle with busy 0 and waits for the next trigger.
- R4: A sw_start pulse has the same effect as a hw_trig pulse: it moves one frame.
- R5: Each element is one read followed by one write of the data that was read. rd_req stays high with a stable rd_addr until rd_vld. wr_req stays high with stable wr_addr and wr_data until wr_ack. rd_req and wr_req are never high together.
- R6: Within a frame, each pointer advances by its own element step after every element. The step is treated as two's complement, and the pointer wraps modulo 2^ADDR_W.
- R7: The first address of each frame after the first is the previous frame's first address plus the frame step, computed separately for source and destination. A zero step makes every frame reuse the same window.
- R8: A trigger that arrives while a frame is in progress is held as pending and starts the next frame when the current one ends. Several such triggers during one frame collapse into a single pending trigger.
- R9: done goes to 1 right after the write acknowledge of the last element of the last frame. At that point busy drops and any pending trigger is discarded.
- R10: While done is 1, hw_trig and sw_start are ignored, and no memory request is issued until the channel is re-armed.
- R11: One armed transfer moves cfg_elem_cnt times cfg_frame_cnt elements in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_arm | input | 1 | Pulse: load configuration and restart the transfer |
| cfg_src_base | input | ADDR_W | Source start address |
| cfg_dst_base | input | ADDR_W | Destination start address |
| cfg_elem_cnt | input | CNT_W | Elements per frame (at least 1) |
| cfg_frame_cnt | input | CNT_W | Frames per transfer (at least 1) |
| cfg_src_elem_step | input | ADDR_W | Source step between elements (two's complement) |
| cfg_dst_elem_step | input | ADDR_W | Destination step between elements (two's complement) |
| cfg_src_frame_step | input | ADDR_W | Source step between frame start addresses |
| cfg_dst_frame_step | input | ADDR_W | Destination step between frame start addresses |
| hw_trig | input | 1 | Hardware request: move one frame |
| sw_start | input | 1 | Software request: move one frame |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_vld | input | 1 | Read data valid; completes the read |
| rd_data | input | DATA_W | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Last frame finished |

## Verification
The first configuration uses a unit source stride with a large frame step and a zero destination frame step. It separates the restart-at-window-base behaviour from plain linear addressing. The second configuration uses a negative element step that wraps through address zero, together with a negative destination frame step. It tells apart correct two's complement arithmetic from unsigned arithmetic, and element stepping from frame stepping. Triggers are also sent during a frame, during the final frame, and after completion. These separate one-frame-per-trigger behaviour, pending-trigger collapse, discard at the end of the transfer, and the ignore-while-done rule. A memory model whose latency varies from element to element checks that the request handshakes are held.

// File: rtl/dma_fc_pkg.sv
package dma_fc_pkg;
  typedef enum logic [1:0] {
    FC_IDLE = 2'd0,
    FC_RD   = 2'd1,
    FC_WR   = 2'd2
  } fc_state_t;
endpackage

// File: rtl/dma_fc_addr_gen.sv
module dma_fc_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] elem_step,
  input  logic [ADDR_W-1:0] frame_step,
  input  logic              adv_elem,
  input  logic              adv_frame,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] cur_q, fstart_q, estep_q, fstep_q;
  logic [ADDR_W-1:0] next_fstart;

  assign next_fstart = fstart_q + fstep_q;
  assign addr        = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      fstart_q <= '0;
      estep_q  <= '0;
      fstep_q  <= '0;
    end else if (load) begin
      cur_q    <= base;
      fstart_q <= base;
      estep_q  <= elem_step;
      fstep_q  <= frame_step;
    end else if (adv_frame) begin
      fstart_q <= next_fstart;
      cur_q    <= next_fstart;
    end else if (adv_elem) begin
      cur_q <= cur_q + estep_q;
    end
  end

  // R2: after a load the pointer sits at the supplied base
  a_r2_load_base: assert property (@(posedge clk) disable iff (rst)
    load |=> addr == $past(base));
endmodule

// File: rtl/dma_fc_seq.sv
module dma_fc_seq
  import dma_fc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [CNT_W-1:0] elem_cnt,
  input  logic [CNT_W-1:0] frame_cnt,
  input  logic             hw_trig,
  input  logic             sw_start,
  input  logic             rd_vld,
  input  logic             wr_ack,
  output logic             rd_req,
  output logic             wr_req,
  output logic             adv_elem,
  output logic             adv_frame,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  fc_state_t        st_q;
  logic [CNT_W-1:0] ecnt_q, fcnt_q, eidx_q, fidx_q;
  logic             pend_q, armed_q, done_q, rd_q, wr_q;
  logic             last_e, last_f, wr_fire, trig_in;

  assign last_e    = (eidx_q == ecnt_q - ONE);
  assign last_f    = (fidx_q == fcnt_q - ONE);
  assign wr_fire   = (st_q == FC_WR) && wr_ack;
  assign trig_in   = (hw_trig || sw_start) && armed_q && !done_q;
  assign adv_elem  = wr_fire;
  assign adv_frame = wr_fire && last_e;
  assign rd_req    = rd_q;
  assign wr_req    = wr_q;
  assign busy      = (st_q != FC_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FC_IDLE;
      ecnt_q  <= ONE;
      fcnt_q  <= ONE;
      eidx_q  <= '0;
      fidx_q  <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (arm) begin
      st_q    <= FC_IDLE;
      ecnt_q  <= elem_cnt;
      fcnt_q  <= frame_cnt;
      eidx_q  <= '0;
      fidx_q  <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      unique case (st_q)
        FC_IDLE: begin
          if (trig_in || pend_q) begin
            st_q   <= FC_RD;
            rd_q   <= 1'b1;
            pend_q <= 1'b0;
          end
        end
        FC_RD: begin
          if (trig_in) pend_q <= 1'b1;
          if (rd_vld) begin
            rd_q <= 1'b0;
            wr_q <= 1'b1;
            st_q <= FC_WR;
          end
        end
        FC_WR: begin
          if (!wr_ack) begin
            if (trig_in) pend_q <= 1'b1;
          end else begin
            wr_q <= 1'b0;
            if (!last_e) begin
              eidx_q <= eidx_q + ONE;
              rd_q   <= 1'b1;
              st_q   <= FC_RD;
              if (trig_in) pend_q <= 1'b1;
            end else begin
              eidx_q <= '0;
              if (last_f) begin
                fidx_q <= '0;
                done_q <= 1'b1;
                pend_q <= 1'b0;
                st_q   <= FC_IDLE;
              end else begin
                fidx_q <= fidx_q + ONE;
                if (pend_q || trig_in) begin
                  pend_q <= 1'b0;
                  rd_q   <= 1'b1;
                  st_q   <= FC_RD;
                end else begin
                  st_q <= FC_IDLE;
                end
              end
            end
          end
        end
        default: st_q <= FC_IDLE;
      endcase
    end
  end

  // R5: read and write requests are mutually exclusive
  a_r5_req_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));
  // R9: done only rises on a write acknowledge
  a_r9_done_on_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(wr_req && wr_ack));
  // R10: no memory traffic while done
  a_r10_quiet_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_req && !wr_req));
  // R2: arming clears completion and stops activity
  a_r2_arm_clear: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!done && !busy));
  // R1: no activity before the first arm
  a_r1_unarmed_idle: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !busy);
endmodule

// File: rtl/dma_frame_chan.sv
module dma_frame_chan #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_arm,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [CNT_W-1:0]  cfg_elem_cnt,
  input  logic [CNT_W-1:0]  cfg_frame_cnt,
  input  logic [ADDR_W-1:0] cfg_src_elem_step,
  input  logic [ADDR_W-1:0] cfg_dst_elem_step,
  input  logic [ADDR_W-1:0] cfg_src_frame_step,
  input  logic [ADDR_W-1:0] cfg_dst_frame_step,
  input  logic              hw_trig,
  input  logic              sw_start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done
);
  logic              adv_elem, adv_frame;
  logic [DATA_W-1:0] data_q;

  dma_fc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .arm       (cfg_arm),
    .elem_cnt  (cfg_elem_cnt),
    .frame_cnt (cfg_frame_cnt),
    .hw_trig   (hw_trig),
    .sw_start  (sw_start),
    .rd_vld    (rd_vld),
    .wr_ack    (wr_ack),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .adv_elem  (adv_elem),
    .adv_frame (adv_frame),
    .busy      (busy),
    .done      (done)
  );

  dma_fc_addr_gen #(.ADDR_W(ADDR_W)) u_src (
    .clk        (clk),
    .rst        (rst),
    .load       (cfg_arm),
    .base       (cfg_src_base),
    .elem_step  (cfg_src_elem_step),
    .frame_step (cfg_src_frame_step),
    .adv_elem   (adv_elem),
    .adv_frame  (adv_frame),
    .addr       (rd_addr)
  );

  dma_fc_addr_gen #(.ADDR_W(ADDR_W)) u_dst (
    .clk        (clk),
    .rst        (rst),
    .load       (cfg_arm),
    .base       (cfg_dst_base),
    .elem_step  (cfg_dst_elem_step),
    .frame_step (cfg_dst_frame_step),
    .adv_elem   (adv_elem),
    .adv_frame  (adv_frame),
    .addr       (wr_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)                   data_q <= '0;
    else if (rd_req && rd_vld) data_q <= rd_data;
  end
  assign wr_data = data_q;

  // R5: a read request is held with a stable address until data returns
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_vld && !cfg_arm) |=> (rd_req && $stable(rd_addr)));
  // R5: a write request is held with stable address and data until accepted
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack && !cfg_arm) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
  // R5: the write after a read carries the data that read returned
  a_r5_wr_data: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_vld && !cfg_arm) |=> (wr_req && wr_data == $past(rd_data)));
endmodule

// File: tb/test_dma_frame_chan.sv
module test_dma_frame_chan;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_arm = 1'b0;
  logic [AW-1:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic [CW-1:0] cfg_elem_cnt = 8'd1, cfg_frame_cnt = 8'd1;
  logic [AW-1:0] cfg_src_elem_step = '0, cfg_dst_elem_step = '0;
  logic [AW-1:0] cfg_src_frame_step = '0, cfg_dst_frame_step = '0;
  logic hw_trig = 1'b0, sw_start = 1'b0;
  logic rd_req, wr_req, busy, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic rd_vld = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic wr_ack = 1'b0;

  always #2 clk = ~clk;

  dma_frame_chan #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dma_frame_chan (
    .clk(clk), .rst(rst), .cfg_arm(cfg_arm),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt),
    .cfg_src_elem_step(cfg_src_elem_step), .cfg_dst_elem_step(cfg_dst_elem_step),
    .cfg_src_frame_step(cfg_src_frame_step), .cfg_dst_frame_step(cfg_dst_frame_step),
    .hw_trig(hw_trig), .sw_start(sw_start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done)
  );

  typedef struct {
    logic [AW-1:0] sa;
    logic [AW-1:0] da;
    logic [DW-1:0] d;
    bit            first;
  } item_t;
  item_t expq[$];

  int checks = 0, fails = 0, n_rd = 0, n_wr = 0, cyc = 0;
  int rwait = 0, rlat = 0, wwait = 0, wlat = 1;
  bit overlap = 0;

  logic [AW-1:0] m_s, m_d, m_sfs, m_dfs, m_se, m_de, m_sf, m_df;
  int m_ec;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (rd_req && wr_req) overlap = 1;
    if (rd_vld) rd_vld = 1'b0;
    else if (rd_req) begin
      if (rwait >= rlat) begin
        rd_vld  = 1'b1;
        rd_data = mem_val(rd_addr);
        n_rd++;
        if (expq.size() == 0) check(0, "R10", "unexpected read", 32'(rd_addr), 0);
        else check(rd_addr == expq[0].sa, expq[0].first ? "R7" : "R6",
                   "read address", 32'(rd_addr), 32'(expq[0].sa));
        rwait = 0;
        rlat  = (rlat + 1) % 3;
      end else rwait++;
    end
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      if (wwait >= wlat) begin
        wr_ack = 1'b1;
        n_wr++;
        if (expq.size() == 0) check(0, "R10", "unexpected write", 32'(wr_addr), 0);
        else begin
          check(wr_addr == expq[0].da, expq[0].first ? "R7" : "R6",
                "write address", 32'(wr_addr), 32'(expq[0].da));
          check(wr_data == expq[0].d, "R5", "write data", 32'(wr_data), 32'(expq[0].d));
          void'(expq.pop_front());
        end
        wwait = 0;
        wlat  = (wlat + 2) % 3;
      end else wwait++;
    end
  end

  task automatic arm_cfg(input logic [AW-1:0] sb, db, input int ec, fc,
                         input logic [AW-1:0] se, de, sf, df);
    @(negedge clk);
    cfg_src_base = sb; cfg_dst_base = db;
    cfg_elem_cnt = CW'(ec); cfg_frame_cnt = CW'(fc);
    cfg_src_elem_step = se; cfg_dst_elem_step = de;
    cfg_src_frame_step = sf; cfg_dst_frame_step = df;
    cfg_arm = 1'b1;
    @(negedge clk);
    cfg_arm = 1'b0;
    m_s = sb; m_sfs = sb; m_d = db; m_dfs = db;
    m_se = se; m_de = de; m_sf = sf; m_df = df; m_ec = ec;
  endtask

  task automatic expect_frame();
    for (int e = 0; e < m_ec; e++) begin
      item_t it;
      it.sa = m_s; it.da = m_d; it.d = mem_val(m_s); it.first = (e == 0);
      expq.push_back(it);
      m_s = m_s + m_se;
      m_d = m_d + m_de;
    end
    m_sfs = m_sfs + m_sf; m_s = m_sfs;
    m_dfs = m_dfs + m_df; m_d = m_dfs;
  endtask

  task automatic pulse(input bit sw);
    @(negedge clk);
    if (sw) sw_start = 1'b1; else hw_trig = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; hw_trig = 1'b0;
  endtask

  task automatic wait_wr(input int target);
    while (n_wr < target) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!rd_req && !wr_req && !busy && !done, "R1", "reset outputs",
          {28'd0, rd_req, wr_req, busy, done}, 0);
    rst = 1'b0;
    pulse(0); pulse(1);
    repeat (8) @(negedge clk);
    check(!busy && n_rd == 0, "R1", "trigger before arm", n_rd, 0);

    // gather: source strides by 64 per frame, destination reuses its window
    arm_cfg(16'h1000, 16'h0200, 4, 3, 16'h0001, 16'h0001, 16'h0040, 16'h0000);
    check(!done && !busy, "R2", "armed idle", {30'd0, busy, done}, 0);
    expect_frame(); pulse(1);
    wait_wr(4); repeat (3) @(negedge clk);
    check(!busy && expq.size() == 0 && n_wr == 4, "R4", "sw start one frame", n_wr, 4);
    check(!done, "R3", "not done after frame 1", done, 0);
    expect_frame(); pulse(0);
    wait_wr(8); repeat (3) @(negedge clk);
    check(!busy && n_rd == 8, "R3", "one frame per trigger", n_rd, 8);
    expect_frame(); pulse(0);
    wait_wr(12); repeat (3) @(negedge clk);
    check(done && !busy, "R9", "done after last frame", {30'd0, busy, done}, 1);
    pulse(0); pulse(1);
    repeat (10) @(negedge clk);
    check(n_rd == 12 && !busy, "R10", "triggers ignored when done", n_rd, 12);
    check(n_wr == 12, "R11", "total elements", n_wr, 12);

    // negative element step wrapping through zero; collapsed pending triggers
    arm_cfg(16'h0001, 16'h0300, 3, 3, 16'hFFFE, 16'h0002, 16'h0100, 16'hFFFA);
    check(!done, "R2", "re-arm clears done", done, 0);
    expect_frame(); expect_frame();
    pulse(0); pulse(0); pulse(0);
    wait_wr(18); repeat (4) @(negedge clk);
    check(!busy && !done && expq.size() == 0 && n_wr == 18, "R8",
          "pending collapses to one frame", n_wr, 18);
    expect_frame(); pulse(1);
    wait_wr(21); repeat (3) @(negedge clk);
    check(done && n_wr == 21, "R11", "nine elements moved", n_wr, 21);

    // pending trigger in the final frame is discarded
    arm_cfg(16'h2000, 16'h0400, 2, 1, 16'h0001, 16'h0001, 16'h0000, 16'h0000);
    expect_frame();
    pulse(0); pulse(0);
    wait_wr(23); repeat (8) @(negedge clk);
    check(done && !busy && n_rd == 23, "R9", "pending discarded at end", n_rd, 23);
    check(!overlap, "R5", "read and write never overlap", overlap, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule